// File: doc/BRIEF.md
# Maskable Event Interrupt and GPIO Controller

This block gathers single-cycle event pulses from a real-time clock and a rising edge on a power-button input. It latches them into a 16-bit sticky status register and raises one level interrupt while any unmasked status bit is set. Software reaches every register through a simple byte-wide register port. It reads status and mask one byte at a time. It clears events by writing ones to a per-byte acknowledge register.

The same register port also drives a small general-purpose I/O port of three lines. A direction register chooses the lines that are inputs. For the other lines an output register gives the value to drive. Reading the input register returns the sampled pins. Lines that are not inputs read back as their own output value. Pin activity never raises an interrupt.

Top module: `evtirq_ctrl`

## Requirements
- R1: After reset the mask is 0x0FFF, status is 0, direction is 0x07, the output register is 0 and `irq` is low.
- R2: `irq` is high exactly when some bit of status AND NOT mask is set. It follows each status or mask change at the same clock edge.
- R3: Address 0x17 holds mask bits 7:0 and address 0x18 holds mask bits 15:8. A write to one of them leaves the other byte unchanged.
- R4: Status bits 7:0 read at 0x19 and bits 15:8 read at 0x1A. An `rtc_tick` pulse sets bit 8, `rtc_alarm` sets bit 9 and `rtc_err` sets bit 10. Each bit stays set until acknowledged. Reading status does not clear it.
- R5: Writing a value to 0x1B clears the status bits 7:0 that are 1 in the value. Writing to 0x1C does the same for bits 15:8. Both addresses read as 0.
- R6: When an event sets a status bit in the same cycle that an acknowledge clears it, the bit stays set. Other acknowledged bits in the same write still clear.
- R7: A 0-to-1 change of `pwr_btn` sets status bit 11. Holding the button high sets nothing more, even after the bit is acknowledged.
- R8: Address 0x1E reads {5'b0, gpio_in OR (NOT dir[2:0] AND out[2:0])}. A direction bit of 1 makes its line an input.
- R9: Address 0x1D (direction) keeps only bits 0x67 of a write. Address 0x1F (output) keeps only bits 0x07. `gpio_drv` equals out[2:0] and `gpio_oe` equals NOT dir[2:0].
- R10: Changes on `gpio_in` never set a status bit and never raise `irq`.
- R11: `reg_rdata` is registered. It shows the register selected by `reg_addr` at the previous clock edge, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rtc_tick | input | 1 | Periodic tick event pulse |
| rtc_alarm | input | 1 | Alarm match event pulse |
| rtc_err | input | 1 | Clock update error event pulse |
| pwr_btn | input | 1 | Power-button level, synchronous to clk |
| gpio_in | input | 3 | Sampled GPIO pin levels |
| gpio_drv | output | 3 | Output values for the GPIO lines |
| gpio_oe | output | 3 | Drive enable per line (1 = output) |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the block with its default parameters: a 16-bit status split into two byte halves, three GPIO lines, and the clock events at bits 8, 9 and 10 with the button at bit 11. With these values it can check that mask and acknowledge writes stay inside their own byte halves. It can also check that an event and an acknowledge on the same bit in the same cycle leave the bit set. All three lines can be put in mixed input and output settings, so the merged readback and the drive enables are checked line by line.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;

  localparam int BUS_AW = 8;
  localparam int BUS_DW = 8;

  // byte-addressed register map; software decodes these offsets
  localparam logic [BUS_AW-1:0] A_MASK_BASE = 8'h17;
  localparam logic [BUS_AW-1:0] A_STAT_BASE = 8'h19;
  localparam logic [BUS_AW-1:0] A_ACK_BASE  = 8'h1B;
  localparam logic [BUS_AW-1:0] A_GDIR      = 8'h1D;
  localparam logic [BUS_AW-1:0] A_GIN       = 8'h1E;
  localparam logic [BUS_AW-1:0] A_GOUT      = 8'h1F;

  localparam logic [BUS_DW-1:0] GDIR_KEEP = 8'h67;
  localparam logic [BUS_DW-1:0] GOUT_KEEP = 8'h07;
  localparam logic [BUS_DW-1:0] GDIR_RST  = 8'h07;

  typedef struct packed {
    logic              we;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] wdata;
  } bus_req_t;

endpackage

// File: rtl/evtirq_edge.sv
module evtirq_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/evtirq_status.sv
module evtirq_status
  import evtirq_pkg::*;
#(
  parameter int              STAT_W   = 16,
  parameter logic [STAT_W-1:0] MASK_RST = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_req_t          req,
  input  logic [STAT_W-1:0] set_vec,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq_q
);
  localparam int NB = STAT_W / BUS_DW;

  logic [STAT_W-1:0] ack_vec;
  logic [STAT_W-1:0] mask_nxt;
  logic [STAT_W-1:0] stat_nxt;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [BUS_AW-1:0] MADR = A_MASK_BASE + 8'(b);
    localparam logic [BUS_AW-1:0] KADR = A_ACK_BASE + 8'(b);
    always_comb begin
      ack_vec[b*BUS_DW +: BUS_DW]  = (req.we && req.addr == KADR) ? req.wdata : '0;
      mask_nxt[b*BUS_DW +: BUS_DW] = (req.we && req.addr == MADR) ? req.wdata
                                                                  : mask_q[b*BUS_DW +: BUS_DW];
    end
  end

  // clear first, then set: an event in the acknowledge cycle survives
  assign stat_nxt = (stat_q & ~ack_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      mask_q <= mask_nxt;
      irq_q  <= |(stat_nxt & ~mask_nxt);
    end
  end
endmodule

// File: rtl/evtirq_gpio.sv
module evtirq_gpio
  import evtirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_req_t          req,
  output logic [BUS_DW-1:0] dir_q,
  output logic [BUS_DW-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= GDIR_RST;
      out_q <= '0;
    end else if (req.we) begin
      if (req.addr == A_GDIR) dir_q <= req.wdata & GDIR_KEEP;
      if (req.addr == A_GOUT) out_q <= req.wdata & GOUT_KEEP;
    end
  end
endmodule

// File: rtl/evtirq_ctrl.sv
module evtirq_ctrl
  import evtirq_pkg::*;
#(
  parameter int GPIO_N   = 3,
  parameter int STAT_W   = 16,
  parameter int TICK_BIT = 8,
  parameter int ALRM_BIT = 9,
  parameter int ERR_BIT  = 10,
  parameter int BTN_BIT  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [BUS_DW-1:0] reg_wdata,
  output logic [BUS_DW-1:0] reg_rdata,
  input  logic              rtc_tick,
  input  logic              rtc_alarm,
  input  logic              rtc_err,
  input  logic              pwr_btn,
  input  logic [GPIO_N-1:0] gpio_in,
  output logic [GPIO_N-1:0] gpio_drv,
  output logic [GPIO_N-1:0] gpio_oe,
  output logic              irq
);
  localparam int NB = STAT_W / BUS_DW;
  localparam logic [STAT_W-1:0] MASK_RST = 16'h0FFF;

  bus_req_t          req;
  logic              btn_rise;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  logic [BUS_DW-1:0] dir_q;
  logic [BUS_DW-1:0] out_q;
  logic [BUS_DW-1:0] gin_byte;
  logic [BUS_DW-1:0] rd_nxt;

  assign req = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

  evtirq_edge u_btn (
    .clk (clk),
    .rst (rst),
    .lvl (pwr_btn),
    .rise(btn_rise)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[TICK_BIT] = rtc_tick;
    set_vec[ALRM_BIT] = rtc_alarm;
    set_vec[ERR_BIT]  = rtc_err;
    set_vec[BTN_BIT]  = btn_rise;
  end

  evtirq_status #(.STAT_W(STAT_W), .MASK_RST(MASK_RST)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .set_vec(set_vec),
    .stat_q (stat_q),
    .mask_q (mask_q),
    .irq_q  (irq)
  );

  evtirq_gpio u_gpio (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .dir_q(dir_q),
    .out_q(out_q)
  );

  assign gpio_drv = out_q[GPIO_N-1:0];
  assign gpio_oe  = ~dir_q[GPIO_N-1:0];

  always_comb begin
    gin_byte             = '0;
    gin_byte[GPIO_N-1:0] = gpio_in | (~dir_q[GPIO_N-1:0] & out_q[GPIO_N-1:0]);
  end

  always_comb begin
    rd_nxt = '0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == 8'(A_MASK_BASE + 8'(b))) rd_nxt = mask_q[b*BUS_DW +: BUS_DW];
      if (reg_addr == 8'(A_STAT_BASE + 8'(b))) rd_nxt = stat_q[b*BUS_DW +: BUS_DW];
    end
    case (reg_addr)
      A_GDIR:  rd_nxt = dir_q;
      A_GIN:   rd_nxt = gin_byte;
      A_GOUT:  rd_nxt = out_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/evtirq_ctrl_chk.sv
module evtirq_ctrl_chk
  import evtirq_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input bus_req_t          req,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] mask_q,
  input logic [BUS_DW-1:0] dir_q
);
  a_r2_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & ~mask_q));

  a_r3_mask_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (req.we && req.addr == A_MASK_BASE) |=> mask_q[STAT_W-1:8] == $past(mask_q[STAT_W-1:8]));

  a_r5_ack_lo_clears: assert property (@(posedge clk) disable iff (rst)
    (req.we && req.addr == A_ACK_BASE && set_vec[7:0] == 8'h00)
      |=> (stat_q[7:0] & $past(req.wdata)) == 8'h00);

  a_r5_ack_hi_clears: assert property (@(posedge clk) disable iff (rst)
    (req.we && req.addr == 8'(A_ACK_BASE + 8'd1) && set_vec[15:8] == 8'h00)
      |=> (stat_q[15:8] & $past(req.wdata)) == 8'h00);

  a_r6_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> (stat_q & $past(set_vec)) == $past(set_vec));

  a_r10_only_sources_set: assert property (@(posedge clk) disable iff (rst)
    !(|set_vec) |=> (stat_q & ~$past(stat_q)) == '0);

  a_r9_dir_keep: assert property (@(posedge clk) disable iff (rst)
    (req.we && req.addr == A_GDIR) |=> dir_q == ($past(req.wdata) & GDIR_KEEP));
endmodule

bind evtirq_ctrl evtirq_ctrl_chk #(.STAT_W(STAT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .req    (req),
  .set_vec(set_vec),
  .stat_q (stat_q),
  .mask_q (mask_q),
  .dir_q  (dir_q)
);

// File: tb/evtirq_ctrl_tb.sv
`timescale 1ns/1ps
module evtirq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rtc_tick = 1'b0, rtc_alarm = 1'b0, rtc_err = 1'b0, pwr_btn = 1'b0;
  logic [2:0] gpio_in = '0;
  logic [2:0] gpio_drv, gpio_oe;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evtirq_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_tick(rtc_tick),
    .rtc_alarm(rtc_alarm), .rtc_err(rtc_err), .pwr_btn(pwr_btn),
    .gpio_in(gpio_in), .gpio_drv(gpio_drv), .gpio_oe(gpio_oe), .irq(irq)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, $sformatf("read %h", a), {8'h00, v}, {8'h00, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", "irq after reset", {15'd0, irq}, 16'd0);
    rd_chk("R1", 8'h17, 8'hFF);
    rd_chk("R1", 8'h18, 8'h0F);
    rd_chk("R1", 8'h19, 8'h00);
    rd_chk("R1", 8'h1A, 8'h00);
    rd_chk("R1", 8'h1D, 8'h07);
    rd_chk("R1", 8'h1F, 8'h00);
    rd_chk("R11", 8'h40, 8'h00);
  endtask

  task automatic t_mask_bytes;
    wr(8'h18, 8'hA5);
    rd_chk("R3", 8'h17, 8'hFF);
    rd_chk("R3", 8'h18, 8'hA5);
    wr(8'h17, 8'h3C);
    rd_chk("R3", 8'h18, 8'hA5);
    rd_chk("R3", 8'h17, 8'h3C);
    wr(8'h17, 8'hFF);
    wr(8'h18, 8'h00);
  endtask

  task automatic t_rtc_events;
    check("R2", "irq idle", {15'd0, irq}, 16'd0);
    @(negedge clk); rtc_tick = 1'b1; @(negedge clk); rtc_tick = 1'b0;
    check("R2", "irq after tick", {15'd0, irq}, 16'd1);
    rd_chk("R4", 8'h1A, 8'h01);
    @(negedge clk); rtc_alarm = 1'b1; rtc_err = 1'b1;
    @(negedge clk); rtc_alarm = 1'b0; rtc_err = 1'b0;
    idle(5);
    rd_chk("R4", 8'h1A, 8'h07);
    rd_chk("R4", 8'h1A, 8'h07);
    wr(8'h18, 8'h01);
    check("R2", "irq bit8 masked, 9/10 pending", {15'd0, irq}, 16'd1);
    wr(8'h1C, 8'h06);
    check("R2", "irq only masked bit left", {15'd0, irq}, 16'd0);
    rd_chk("R5", 8'h1A, 8'h01);
    rd_chk("R5", 8'h1C, 8'h00);
    rd_chk("R5", 8'h1B, 8'h00);
    wr(8'h18, 8'h00);
    check("R2", "irq after unmask", {15'd0, irq}, 16'd1);
    wr(8'h1B, 8'hFF);
    rd_chk("R5", 8'h1A, 8'h01);
    wr(8'h1C, 8'h01);
    rd_chk("R5", 8'h1A, 8'h00);
    check("R2", "irq after ack", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_set_wins;
    @(negedge clk); rtc_tick = 1'b1; rtc_alarm = 1'b1;
    @(negedge clk); rtc_tick = 1'b0; rtc_alarm = 1'b0;
    rd_chk("R6", 8'h1A, 8'h03);
    @(negedge clk);
    rtc_tick = 1'b1; reg_we = 1'b1; reg_addr = 8'h1C; reg_wdata = 8'h03;
    @(negedge clk);
    rtc_tick = 1'b0; reg_we = 1'b0;
    rd_chk("R6", 8'h1A, 8'h01);
    check("R6", "irq kept", {15'd0, irq}, 16'd1);
    wr(8'h1C, 8'h01);
    rd_chk("R6", 8'h1A, 8'h00);
  endtask

  task automatic t_button;
    @(negedge clk); pwr_btn = 1'b1;
    idle(2);
    rd_chk("R7", 8'h1A, 8'h08);
    check("R7", "irq on press", {15'd0, irq}, 16'd1);
    wr(8'h1C, 8'h08);
    idle(5);
    rd_chk("R7", 8'h1A, 8'h00);
    check("R7", "irq while held", {15'd0, irq}, 16'd0);
    @(negedge clk); pwr_btn = 1'b0;
    idle(2);
    rd_chk("R7", 8'h1A, 8'h00);
    @(negedge clk); pwr_btn = 1'b1;
    idle(2);
    rd_chk("R7", 8'h1A, 8'h08);
    wr(8'h1C, 8'h08);
    @(negedge clk); pwr_btn = 1'b0;
  endtask

  task automatic t_gpio;
    wr(8'h1F, 8'hFF);
    rd_chk("R9", 8'h1F, 8'h07);
    rd_chk("R8", 8'h1E, 8'h00);
    check("R9", "drv", {13'd0, gpio_drv}, 16'h0007);
    check("R9", "oe all inputs", {13'd0, gpio_oe}, 16'h0000);
    wr(8'h1D, 8'hFF);
    rd_chk("R9", 8'h1D, 8'h67);
    wr(8'h1D, 8'h02);
    rd_chk("R9", 8'h1D, 8'h02);
    check("R9", "oe mixed", {13'd0, gpio_oe}, 16'h0005);
    rd_chk("R8", 8'h1E, 8'h05);
    wr(8'h1F, 8'h04);
    rd_chk("R8", 8'h1E, 8'h04);
    @(negedge clk); gpio_in = 3'b010;
    rd_chk("R8", 8'h1E, 8'h06);
    wr(8'h1D, 8'h07);
    @(negedge clk); gpio_in = 3'b001;
    rd_chk("R8", 8'h1E, 8'h01);
  endtask

  task automatic t_gpio_no_irq;
    wr(8'h17, 8'h00);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); gpio_in = 3'(i);
    end
    idle(2);
    rd_chk("R10", 8'h19, 8'h00);
    rd_chk("R10", 8'h1A, 8'h00);
    check("R10", "irq after pin toggles", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask_bytes();
    t_rtc_events();
    t_set_wins();
    t_button();
    t_gpio();
    t_gpio_no_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule